// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block takes a two-channel PCM stream from an external serial port (bit clock, frame clock and data) and turns it into parallel left and right samples inside a faster system clock domain. The three serial lines pass through synchronizers, and the rising edges of the bit clock are found by oversampling. A format input chosen while the block is in reset selects one of two framings. In the first, the word is left-justified against the frame clock edge. In the second, the word starts one bit clock after the frame clock edge, as in I2S.

The block counts bit clocks over each full frame to find the bit-clock ratio. At 64 or 128 clocks per frame it extracts 24-bit words. At 32 clocks per frame it accepts only the I2S framing with 16-bit words, and places each word in the upper part of the 24-bit output. Any other frame length raises an error flag and withholds the output strobe. Each accepted frame gives one single-cycle strobe, and both channel outputs change together with it.

Top module: `serial_audio_rx`

## Requirements
- R1: With `fmt_i2s_i` low, the frame clock high half carries the left word and the low half carries the right word. The MSB is captured at the first bit-clock rising edge after the frame clock changes, and bits follow MSB first for 24 slots. Two's complement values are passed bit-exact.
- R2: With `fmt_i2s_i` high, the frame clock low half carries the left word and the high half carries the right word. The MSB is captured at the second bit-clock rising edge after the frame clock changes.
- R3: Frames of 64 and 128 bit clocks are accepted in both formats and give full 24-bit words. Slots after the 24th in each half are ignored.
- R4: In I2S format, a frame of 32 bit clocks is accepted with 16-bit words. Output bits 23:8 hold the word and bits 7:0 are zero.
- R5: A measured frame length other than 32, 64 or 128 bit clocks, or 32 in left-justified format, drives `frame_err_o` high and produces no `valid_o` pulse.
- R6: `valid_o` is high for exactly one system clock per accepted frame, after both halves of that frame have been received. `left_o` and `right_o` change only in the cycle in which `valid_o` is high.
- R7: `frame_err_o` is re-evaluated once per frame. It returns low after the first frame of a legal length, and strobes resume with that frame.
- R8: While `rst` is high and after it is released, `valid_o` and `frame_err_o` are low and both sample outputs are zero until the first accepted frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the bit clock rate |
| rst | input | 1 | Synchronous active-high reset |
| fmt_i2s_i | input | 1 | Framing select: 0 left-justified, 1 I2S; change only during reset |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| lrck_i | input | 1 | Serial frame clock (asynchronous) |
| sdata_i | input | 1 | Serial data, MSB first, two's complement |
| left_o | output | 24 | Left channel sample |
| right_o | output | 24 | Right channel sample |
| valid_o | output | 1 | One-cycle strobe when a new sample pair is presented |
| frame_err_o | output | 1 | Last measured frame length is not legal for the format |

## Verification
The bench sweeps both framings at 64 and 128 clocks per frame and sends distinct words to each channel. A channel swap, a one-slot offset or a bit-order error therefore shows up in the captured values. I2S at 32 clocks per frame uses words with nonzero low bytes, which shows whether the 16-bit alignment and zero fill are correct. It also exercises the last data bit that falls into the next half. Illegal lengths (32 in left-justified mode, 48, 96) confirm that the error is flagged and strobes are suppressed. A stream that goes from an illegal length to a legal one confirms the recovery point. Extreme two's complement values are included to catch sign or truncation faults.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
  // one bit-clock rising edge, decoded into frame position
  typedef struct packed {
    logic       rise;   // a bit-clock rising edge was seen this cycle
    logic       dbit;   // data value at that edge
    logic       left;   // edge belongs to the left-channel half
    logic       start;  // edge is the first slot of a half
  } slot_evt_t;
endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/sarx_slot_track.sv
module sarx_slot_track
  import sarx_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fmt_i2s,
  input  logic             bclk_s,
  input  logic             lrck_s,
  input  logic             data_s,
  output slot_evt_t        evt,
  output logic [CNT_W-1:0] slot
);
  localparam logic [CNT_W-1:0] SLOT_MAX = '1;

  logic             bclk_d, lr_q, eff_q;
  logic [CNT_W-1:0] slot_q;
  logic             rise, eff_now, edge_now;

  assign rise     = bclk_s & ~bclk_d;
  // I2S framing is left-justified framing with the frame clock one slot late
  assign eff_now  = fmt_i2s ? lr_q : lrck_s;
  assign edge_now = eff_now != eff_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_d <= 1'b0;
      lr_q   <= fmt_i2s;
      eff_q  <= fmt_i2s;
      slot_q <= '0;
    end else begin
      bclk_d <= bclk_s;
      if (rise) begin
        lr_q  <= lrck_s;
        eff_q <= eff_now;
        if (edge_now)              slot_q <= CNT_W'(1);
        else if (slot_q != SLOT_MAX) slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign evt.rise  = rise;
  assign evt.dbit  = data_s;
  assign evt.left  = fmt_i2s ? ~eff_now : eff_now;
  assign evt.start = edge_now;
  assign slot      = edge_now ? '0 : slot_q;
endmodule

// File: rtl/sarx_ratio_det.sv
module sarx_ratio_det
  import sarx_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      fmt_i2s,
  input  slot_evt_t evt,
  output logic      meas_valid,
  output logic      ratio_ok
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt, meas;
  logic             seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      meas       <= '0;
      seen       <= 1'b0;
      meas_valid <= 1'b0;
    end else if (evt.rise) begin
      if (evt.start && evt.left) begin
        if (seen) begin
          meas       <= cnt;
          meas_valid <= 1'b1;
        end
        seen <= 1'b1;
        cnt  <= CNT_W'(1);
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign ratio_ok = (meas == CNT_W'(64)) || (meas == CNT_W'(128)) ||
                    ((meas == CNT_W'(32)) && fmt_i2s);
endmodule

// File: rtl/sarx_word_cap.sv
module sarx_word_cap
  import sarx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  slot_evt_t           evt,
  input  logic [CNT_W-1:0]    slot,
  output logic [SAMPLE_W-1:0] pair_l,
  output logic [SAMPLE_W-1:0] pair_r,
  output logic                pair_stb
);
  logic [SAMPLE_W-1:0] word, left_hold;
  logic                left_ok, started;

  always_ff @(posedge clk) begin
    if (rst) begin
      word      <= '0;
      left_hold <= '0;
      left_ok   <= 1'b0;
      started   <= 1'b0;
      pair_l    <= '0;
      pair_r    <= '0;
      pair_stb  <= 1'b0;
    end else begin
      pair_stb <= 1'b0;
      if (evt.rise) begin
        if (evt.start) begin
          if (started) begin
            if (!evt.left) begin
              // left half just ended
              left_hold <= word;
              left_ok   <= 1'b1;
            end else if (left_ok) begin
              pair_l   <= left_hold;
              pair_r   <= word;
              pair_stb <= 1'b1;
              left_ok  <= 1'b0;
            end
          end
          started <= 1'b1;
          word    <= {evt.dbit, {(SAMPLE_W-1){1'b0}}};
        end else begin
          for (int k = 1; k < SAMPLE_W; k++)
            if (slot == CNT_W'(k)) word[SAMPLE_W-1-k] <= evt.dbit;
        end
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fmt_i2s_i,
  input  logic                bclk_i,
  input  logic                lrck_i,
  input  logic                sdata_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o,
  output logic                frame_err_o
);
  logic [2:0]          pins_s;
  slot_evt_t           evt;
  logic [CNT_W-1:0]    slot;
  logic                meas_valid, ratio_ok, pair_stb;
  logic [SAMPLE_W-1:0] pair_l, pair_r;

  sarx_sync #(.N(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d({sdata_i, lrck_i, bclk_i}), .q(pins_s));

  sarx_slot_track #(.CNT_W(CNT_W)) track_i (
    .clk(clk), .rst(rst), .fmt_i2s(fmt_i2s_i), .bclk_s(pins_s[0]),
    .lrck_s(pins_s[1]), .data_s(pins_s[2]), .evt(evt), .slot(slot));

  sarx_ratio_det #(.CNT_W(CNT_W)) ratio_i (
    .clk(clk), .rst(rst), .fmt_i2s(fmt_i2s_i), .evt(evt),
    .meas_valid(meas_valid), .ratio_ok(ratio_ok));

  sarx_word_cap #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) cap_i (
    .clk(clk), .rst(rst), .evt(evt), .slot(slot),
    .pair_l(pair_l), .pair_r(pair_r), .pair_stb(pair_stb));

  always_ff @(posedge clk) begin
    if (rst) begin
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      frame_err_o <= meas_valid & ~ratio_ok;
      valid_o     <= pair_stb & meas_valid & ratio_ok;
      if (pair_stb && meas_valid && ratio_ok) begin
        left_o  <= pair_l;
        right_o <= pair_r;
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst,
  input logic [SAMPLE_W-1:0] left_o,
  input logic [SAMPLE_W-1:0] right_o,
  input logic                valid_o,
  input logic                frame_err_o
);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  a_r6_hold_outputs: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  a_r5_err_no_valid: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |-> !valid_o);

  a_r8_reset_quiet: assert property (@(posedge clk)
    rst |=> (!valid_o && !frame_err_o && left_o == '0 && right_o == '0));
endmodule

bind serial_audio_rx serial_audio_rx_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
  .clk(clk), .rst(rst), .left_o(left_o), .right_o(right_o),
  .valid_o(valid_o), .frame_err_o(frame_err_o));

// File: tb/serial_audio_rx_tb_top.sv
module serial_audio_rx_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, fmt, bclk, lrck, sd;
  logic [23:0] left, right;
  logic        valid, ferr;

  serial_audio_rx dut_i (
    .clk(clk), .rst(rst), .fmt_i2s_i(fmt), .bclk_i(bclk), .lrck_i(lrck),
    .sdata_i(sd), .left_o(left), .right_o(right), .valid_o(valid),
    .frame_err_o(ferr));

  int n_chk = 0, n_err = 0, vcount;
  logic [23:0] cap_l [16];
  logic [23:0] cap_r [16];
  logic [23:0] prev_w;
  logic [23:0] wl [8];
  logic [23:0] wr [8];

  always @(posedge clk) begin
    if (rst) vcount <= 0;
    else if (valid) begin
      if (vcount < 16) begin
        cap_l[vcount] <= left;
        cap_r[vcount] <= right;
      end
      vcount <= vcount + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit f);
    @(negedge clk);
    fmt = f; rst = 1'b1; bclk = 1'b0; lrck = f; sd = 1'b0; prev_w = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_slot(input bit lv, input bit d);
    bclk = 1'b0; lrck = lv; sd = d;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic bit wbit(input logic [23:0] w, input int j, input int half);
    return (j < 24 && j < half) ? w[23-j] : 1'b0;
  endfunction

  task automatic send_frame(input bit f, input int half,
                            input logic [23:0] l, input logic [23:0] r);
    for (int h = 0; h < 2; h++) begin
      logic [23:0] cur;
      bit lv;
      cur = (h == 0) ? l : r;
      lv  = f ? bit'(h) : ~bit'(h);
      for (int s = 0; s < half; s++) begin
        bit d;
        if (!f)         d = wbit(cur, s, half);
        else if (s == 0) d = wbit(prev_w, half - 1, half);
        else            d = wbit(cur, s - 1, half);
        send_slot(lv, d);
      end
      prev_w = cur;
    end
  endtask

  task automatic make_words(input int seed);
    for (int k = 0; k < 8; k++) begin
      wl[k] = 24'(32'h9E3779B1 * 32'(seed * 16 + k + 1));
      wr[k] = 24'(32'h7F4A7C15 * 32'(seed * 16 + k + 3) + 32'h00A5);
    end
  endtask

  task automatic run_good(input bit f, input int half, input int nfr,
                          input string req);
    logic [23:0] mask;
    mask = (half == 16) ? 24'hFFFF00 : 24'hFFFFFF;
    do_reset(f);
    for (int k = 0; k < nfr; k++) send_frame(f, half, wl[k], wr[k]);
    send_frame(f, half, 24'h0, 24'h0);
    repeat (20) @(negedge clk);
    chk(vcount == nfr, req, "strobe count", vcount, nfr);
    chk(ferr == 1'b0, req, "frame error low", ferr, 0);
    for (int k = 0; k < nfr; k++) begin
      chk(cap_l[k] == (wl[k] & mask), req, "left word", cap_l[k], wl[k] & mask);
      chk(cap_r[k] == (wr[k] & mask), req, "right word", cap_r[k], wr[k] & mask);
    end
  endtask

  task automatic run_bad(input bit f, input int half);
    do_reset(f);
    for (int k = 0; k < 4; k++) send_frame(f, half, wl[k], wr[k]);
    repeat (20) @(negedge clk);
    chk(vcount == 0, "R5", "no strobe on illegal length", vcount, 0);
    chk(ferr == 1'b1, "R5", "frame error raised", ferr, 1);
    chk(left == 24'h0 && right == 24'h0, "R5", "outputs untouched", left, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    // R8: quiet after reset
    chk(valid == 1'b0 && ferr == 1'b0, "R8", "flags after reset", {valid, ferr}, 0);
    chk(left == 24'h0 && right == 24'h0, "R8", "samples after reset", left | right, 0);

    // R1: left-justified, extreme two's complement values
    wl[0] = 24'h800000; wr[0] = 24'h7FFFFF;
    wl[1] = 24'hFFFFFF; wr[1] = 24'h000001;
    wl[2] = 24'h123456; wr[2] = 24'hABCDEF;
    run_good(1'b0, 32, 3, "R1");
    // R2: I2S with the same extremes
    run_good(1'b1, 32, 3, "R2");

    // R3: sweep both formats at 64 and 128 slots per frame
    for (int f = 0; f < 2; f++)
      for (int q = 0; q < 2; q++) begin
        make_words(f * 2 + q + 1);
        run_good(bit'(f), (q == 0) ? 32 : 64, 4, "R3");
      end

    // R4: I2S at 32 slots per frame, 16-bit words
    make_words(7);
    run_good(1'b1, 16, 5, "R4");

    // R5: illegal lengths
    make_words(9);
    run_bad(1'b0, 16);
    run_bad(1'b0, 24);
    run_bad(1'b1, 48);

    // R7: illegal then legal frames in one stream
    do_reset(1'b0);
    make_words(11);
    send_frame(1'b0, 24, wl[0], wr[0]);
    send_frame(1'b0, 24, wl[1], wr[1]);
    send_frame(1'b0, 32, wl[2], wr[2]);
    repeat (20) @(negedge clk);
    chk(ferr == 1'b1, "R7", "error while short frames", ferr, 1);
    send_frame(1'b0, 32, wl[3], wr[3]);
    send_frame(1'b0, 32, wl[4], wr[4]);
    send_frame(1'b0, 32, 24'h0, 24'h0);
    repeat (20) @(negedge clk);
    chk(ferr == 1'b0, "R7", "error cleared", ferr, 0);
    chk(vcount == 3, "R7", "strobes resume", vcount, 3);
    chk(cap_l[0] == wl[2] && cap_r[0] == wr[2], "R7", "first legal frame", cap_l[0], wl[2]);
    chk(cap_l[2] == wl[4] && cap_r[2] == wr[4], "R6", "last pair together", cap_r[2], wr[4]);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule